// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps wall-clock time and a calendar date in packed BCD. It counts seconds, minutes and hours, then day, month and a two-digit year, and it also tracks the day of the week and shows whether the current year is a leap year. The block does not see real seconds directly. It counts a base tick input, and every `TICKS_PER_SEC` ticks it produces one second step.

Software sets the clock by writing a time word, a date word or a weekday through three separate load strobes. The block does no conversion between hour codings. The `hour24` input only chooses which rollover rules apply to the hour value that is stored. In 12-hour coding, afternoon hours carry +20 in BCD, so 1 PM is 21 and noon is 32. The counter moves through this coding directly, and the carry out of the last second of the day advances the date and the weekday.

Top module: `bcd_clock_cal`

## Requirements
- R1: After reset, the outputs read as follows: time word 0x000000, date word 0x000101 (day 01, month 01, year 00), weekday 0. The seconds phase starts at zero.
- R2: The seconds value advances by one on the cycle that takes in the `TICKS_PER_SEC`-th base tick since the last step or the last load. On every other cycle with no load, the time, date and weekday hold.
- R3: In the time word, the seconds units sit in [3:0], the seconds tens in [6:4], the minutes units in [11:8], the minutes tens in [14:12], the hours units in [19:16] and the hours tens in [21:20]. Seconds and minutes count in BCD from 00 to 59. Each wraps to 00 and carries into the next field.
- R4: With `hour24`=1, hours count 00 to 23 in BCD. The step after 23:59:59 gives 00:00:00 and advances the date.
- R5: With `hour24`=0, the morning hours are 12, 01..11 and the afternoon hours are 32, 21..31. The steps are 11:59:59 to 32:00:00, 12:59:59 to 01:00:00, and 32:59:59 to 21:00:00. The step after 31:59:59 gives 12:00:00 and advances the date.
- R6: In the date word, the day units sit in [3:0], the day tens in [5:4], the month units in [11:8], the month tens in bit 12, the year units in [19:16] and the year tens in [23:20]. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months apart from February. After the last day, the day becomes 01 and the month steps. Month 12 wraps to 01 and steps the year, and year 99 wraps to 00.
- R7: `leap_q` is 1 exactly when the year value is a multiple of 4 (00 counts as one). February ends after day 29 when `leap_q` is 1 and after day 28 when it is 0.
- R8: The weekday (0 = Sunday .. 6 = Saturday) advances whenever the date advances, and it wraps from 6 to 0. A weekday load sets it directly.
- R9: A time, date or weekday load appears at the outputs on the next cycle. A load takes priority over a base tick in the same cycle and restarts the seconds phase. Bits 7, 15, 22 and 23 of the time word, and bits 6, 7 and 13 to 15 of the date word, always read as 0.
- R10: A change of `hour24` by itself leaves the stored time, date and weekday unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hour24 | input | 1 | 1 = 24-hour coding, 0 = 12-hour coding with PM at +20 |
| base_tick | input | 1 | Sub-second enable, one per base period |
| time_ld | input | 1 | Load the time word |
| time_din | input | 24 | Time word to load |
| date_ld | input | 1 | Load the date word |
| date_din | input | 24 | Date word to load |
| wday_ld | input | 1 | Load the weekday |
| wday_din | input | 3 | Weekday to load |
| time_q | output | 24 | Current packed time |
| date_q | output | 24 | Current packed date |
| wday_q | output | 3 | Current weekday |
| leap_q | output | 1 | Current year is a leap year |

## Verification
The assertions check four things on every cycle. Time and date hold when there is neither a second step nor a load. Loads land unchanged apart from the masked holes. The seconds units advance on each step. The date moves only after the final second of the day in the active coding, and each date move advances the weekday by one modulo 7. The bench scenarios are needed for the rest, because that part depends on exact sequences of values: the 12-hour noon and midnight codes, the month lengths, February in leap and common years, the wrap at the end of the century, and a load that restarts a partly counted second.

// File: rtl/bcd_clk_pkg.sv
package bcd_clk_pkg;
  localparam int WORD_W = 24;
  localparam int WDAY_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [WORD_W-1:0] TIME_MASK = 24'h3F7F7F;
  localparam logic [WORD_W-1:0] DATE_MASK = 24'hFF1F3F;
  localparam logic [WORD_W-1:0] DATE_RST  = 24'h000101;
  localparam logic [WDAY_W-1:0] WDAY_LAST = 3'd6;

  typedef logic [BYTE_W-1:0] bcd8_t;

  // Two-digit BCD increment; the caller handles the wrap point.
  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  // Multiple of four in BCD: even tens need units 0/4/8, odd tens need 2/6.
  function automatic logic yr_is_leap(bcd8_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd8_t month_last_day(bcd8_t m, logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bcd_sec_phase.sv
module bcd_sec_phase #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick,
  input  logic restart,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign sec_pulse = base_tick && !restart && (cnt_q == LAST);
  assign cnt_en    = restart || base_tick;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)                cnt_d = '0;
    else if (cnt_q == LAST)     cnt_d = '0;
    else                        cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bcd_time_ctr.sv
module bcd_time_ctr
  import bcd_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              hour24,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_val,
  output logic [WORD_W-1:0] time_q,
  output logic              day_carry
);
  bcd8_t sec_q, min_q, hr_q;
  bcd8_t sec_d, min_d, hr_d;
  logic  sec_wrap, min_wrap, hr_wrap;
  bcd8_t hr_step;
  logic  upd_en;

  assign sec_wrap = (sec_q >= 8'h59);
  assign min_wrap = (min_q >= 8'h59);

  // Hour successor in the selected coding, with the end-of-day flag.
  always_comb begin
    hr_wrap = 1'b0;
    hr_step = bcd_inc(hr_q);
    if (hour24) begin
      if (hr_q >= 8'h23) begin
        hr_step = 8'h00;
        hr_wrap = 1'b1;
      end
    end else begin
      case (hr_q)
        8'h11: hr_step = 8'h32;
        8'h12: hr_step = 8'h01;
        8'h32: hr_step = 8'h21;
        8'h31: begin
          hr_step = 8'h12;
          hr_wrap = 1'b1;
        end
        default: hr_step = bcd_inc(hr_q);
      endcase
    end
  end

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    hr_d  = hr_q;
    if (ld) begin
      {hr_d, min_d, sec_d} = ld_val & TIME_MASK;
    end else if (step) begin
      sec_d = sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (sec_wrap) begin
        min_d = min_wrap ? 8'h00 : bcd_inc(min_q);
        if (min_wrap) hr_d = hr_step;
      end
    end
  end

  assign upd_en    = ld || step;
  assign day_carry = step && !ld && sec_wrap && min_wrap && hr_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else if (upd_en) begin
      sec_q <= sec_d;
      min_q <= min_d;
      hr_q  <= hr_d;
    end
  end

  assign time_q = {hr_q, min_q, sec_q};
endmodule

// File: rtl/bcd_date_ctr.sv
module bcd_date_ctr
  import bcd_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_val,
  input  logic              wd_ld,
  input  logic [WDAY_W-1:0] wd_val,
  output logic [WORD_W-1:0] date_q,
  output logic [WDAY_W-1:0] wday_q,
  output logic              leap_q
);
  bcd8_t day_q, mon_q, yr_q;
  bcd8_t day_d, mon_d, yr_d;
  logic [WDAY_W-1:0] wd_q, wd_d;
  logic  last_day, last_mon, date_en, wd_en;

  assign leap_q   = yr_is_leap(yr_q);
  assign last_day = (day_q >= month_last_day(mon_q, leap_q));
  assign last_mon = (mon_q >= 8'h12);

  always_comb begin
    day_d = day_q;
    mon_d = mon_q;
    yr_d  = yr_q;
    if (ld) begin
      {yr_d, mon_d, day_d} = ld_val & DATE_MASK;
    end else if (adv) begin
      day_d = last_day ? 8'h01 : bcd_inc(day_q);
      if (last_day) begin
        mon_d = last_mon ? 8'h01 : bcd_inc(mon_q);
        if (last_mon) yr_d = (yr_q >= 8'h99) ? 8'h00 : bcd_inc(yr_q);
      end
    end
  end

  always_comb begin
    wd_d = wd_q;
    if (wd_ld)                  wd_d = wd_val;
    else if (wd_q >= WDAY_LAST) wd_d = '0;
    else                        wd_d = wd_q + WDAY_W'(1);
  end

  assign date_en = ld || adv;
  assign wd_en   = wd_ld || adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {yr_q, mon_q, day_q} <= DATE_RST;
    end else if (date_en) begin
      day_q <= day_d;
      mon_q <= mon_d;
      yr_q  <= yr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wd_q <= '0;
    else if (wd_en) wd_q <= wd_d;
  end

  assign date_q = {yr_q, mon_q, day_q};
  assign wday_q = wd_q;
endmodule

// File: rtl/bcd_clock_cal.sv
module bcd_clock_cal
  import bcd_clk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4,
  parameter int RST_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hour24,
  input  logic              base_tick,
  input  logic              time_ld,
  input  logic [WORD_W-1:0] time_din,
  input  logic              date_ld,
  input  logic [WORD_W-1:0] date_din,
  input  logic              wday_ld,
  input  logic [WDAY_W-1:0] wday_din,
  output logic [WORD_W-1:0] time_q,
  output logic [WORD_W-1:0] date_q,
  output logic [WDAY_W-1:0] wday_q,
  output logic              leap_q
);
  logic rst_int_n;
  logic any_ld;
  logic sec_pulse;
  logic day_carry;

  assign any_ld = time_ld || date_ld || wday_ld;

  bcd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bcd_sec_phase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_phase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .base_tick (base_tick),
    .restart   (any_ld),
    .sec_pulse (sec_pulse)
  );

  bcd_time_ctr u_time (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step      (sec_pulse),
    .hour24    (hour24),
    .ld        (time_ld),
    .ld_val    (time_din),
    .time_q    (time_q),
    .day_carry (day_carry)
  );

  bcd_date_ctr u_date (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .adv    (day_carry),
    .ld     (date_ld),
    .ld_val (date_din),
    .wd_ld  (wday_ld),
    .wd_val (wday_din),
    .date_q (date_q),
    .wday_q (wday_q),
    .leap_q (leap_q)
  );
endmodule

// File: rtl/bcd_clock_cal_chk.sv
module bcd_clock_cal_chk
  import bcd_clk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hour24,
  input logic              sec_pulse,
  input logic              time_ld,
  input logic [WORD_W-1:0] time_din,
  input logic              date_ld,
  input logic [WORD_W-1:0] date_din,
  input logic              wday_ld,
  input logic [WORD_W-1:0] time_q,
  input logic [WORD_W-1:0] date_q,
  input logic [WDAY_W-1:0] wday_q
);
  logic any_ld, end_of_day;
  assign any_ld     = time_ld || date_ld || wday_ld;
  assign end_of_day = hour24 ? (time_q == 24'h235959) : (time_q == 24'h315959);

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ld && !sec_pulse) |=> ($stable(time_q) && $stable(date_q) && $stable(wday_q))); // R2

  AST_SEC_UNITS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !any_ld && time_q[3:0] < 4'd9) |=> (time_q[3:0] == $past(time_q[3:0]) + 4'd1)); // R3

  AST_DATE_ONLY_AT_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (!date_ld && !(sec_pulse && end_of_day)) |=> $stable(date_q)); // R4

  AST_WDAY_FOLLOWS_DATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!date_ld && !wday_ld && sec_pulse && end_of_day) |=>
      (wday_q == (($past(wday_q) >= 3'd6) ? 3'd0 : $past(wday_q) + 3'd1))); // R8

  AST_TIME_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    time_ld |=> (time_q == ($past(time_din) & TIME_MASK))); // R9

  AST_DATE_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    date_ld |=> (date_q == ($past(date_din) & DATE_MASK))); // R9
endmodule

bind bcd_clock_cal bcd_clock_cal_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .hour24    (hour24),
  .sec_pulse (sec_pulse),
  .time_ld   (time_ld),
  .time_din  (time_din),
  .date_ld   (date_ld),
  .date_din  (date_din),
  .wday_ld   (wday_ld),
  .time_q    (time_q),
  .date_q    (date_q),
  .wday_q    (wday_q)
);

// File: tb/tb_bcd_clock_cal.sv
`timescale 1ns/1ps
module tb_bcd_clock_cal;
  localparam int TPS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hour24 = 1'b0;
  logic        base_tick = 1'b0;
  logic        time_ld = 1'b0, date_ld = 1'b0, wday_ld = 1'b0;
  logic [23:0] time_din = '0, date_din = '0;
  logic [2:0]  wday_din = '0;
  logic [23:0] time_q, date_q;
  logic [2:0]  wday_q;
  logic        leap_q;

  always #2.5 clk = ~clk;

  bcd_clock_cal #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .hour24(hour24), .base_tick(base_tick),
    .time_ld(time_ld), .time_din(time_din), .date_ld(date_ld), .date_din(date_din),
    .wday_ld(wday_ld), .wday_din(wday_din),
    .time_q(time_q), .date_q(date_q), .wday_q(wday_q), .leap_q(leap_q)
  );

  int nvec = 0, nfail = 0;
  logic [23:0] m_t, m_d;
  logic [2:0]  m_w;
  int          m_ph;
  string       tag_t = "R1", tag_d = "R1";

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic leapf(logic [7:0] yb);
    return (from_bcd(yb) % 4) == 0;
  endfunction

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] nxt(logic [7:0] b, int lim, int wrap_to);
    return (from_bcd(b) >= lim) ? to_bcd(wrap_to) : to_bcd(from_bcd(b) + 1);
  endfunction

  // Advance the model by one second, following R3..R8.
  task automatic model_second();
    logic [7:0] s, mi, h, dd, mo, yy;
    logic day_adv;
    s = m_t[7:0]; mi = m_t[15:8]; h = m_t[23:16];
    dd = m_d[7:0]; mo = m_d[15:8]; yy = m_d[23:16];
    day_adv = 1'b0;
    s = nxt(s, 59, 0);
    if (s == 8'h00) begin
      mi = nxt(mi, 59, 0);
      if (mi == 8'h00) begin
        if (hour24) begin
          day_adv = (h == 8'h23);
          h = nxt(h, 23, 0);
        end else begin
          case (h)
            8'h11: h = 8'h32;
            8'h12: h = 8'h01;
            8'h32: h = 8'h21;
            8'h31: begin h = 8'h12; day_adv = 1'b1; end
            default: h = to_bcd(from_bcd(h) + 1);
          endcase
        end
      end
    end
    if (day_adv) begin
      if (from_bcd(dd) >= dim(from_bcd(mo), from_bcd(yy))) begin
        dd = 8'h01;
        if (mo == 8'h12) begin
          mo = 8'h01;
          yy = nxt(yy, 99, 0);
        end else mo = to_bcd(from_bcd(mo) + 1);
      end else dd = to_bcd(from_bcd(dd) + 1);
      m_w = (m_w == 3'd6) ? 3'd0 : m_w + 3'd1;
    end
    m_t = {h, mi, s};
    m_d = {yy, mo, dd};
  endtask

  task automatic cmp(logic [23:0] act, logic [23:0] exp, string tag, string what);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp(time_q, m_t, tag_t, "time");
    cmp(date_q, m_d, tag_d, "date");
    cmp({21'd0, wday_q}, {21'd0, m_w}, "R8", "weekday");
    cmp({23'd0, leap_q}, {23'd0, leapf(m_d[23:16])}, "R7", "leap");
  endtask

  // Drive one cycle at the falling edge, predict, check at the next falling edge.
  task automatic step(logic tk, logic tl, logic [23:0] tv, logic dl, logic [23:0] dv,
                      logic wl, logic [2:0] wv);
    base_tick = tk; time_ld = tl; time_din = tv;
    date_ld = dl; date_din = dv; wday_ld = wl; wday_din = wv;
    if (tl || dl || wl) begin
      if (tl) m_t = tv & 24'h3F7F7F;
      if (dl) m_d = dv & 24'hFF1F3F;
      if (wl) m_w = wv;
      m_ph = 0;
    end else if (tk) begin
      if (m_ph == TPS - 1) begin
        m_ph = 0;
        model_second();
      end else m_ph++;
    end
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic load_all(logic m24, logic [23:0] tv, logic [23:0] dv, logic [2:0] wv);
    hour24 = m24;
    step(1'b0, 1'b1, tv, 1'b1, dv, 1'b1, wv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_t = 24'h000000; m_d = 24'h000101; m_w = 3'd0; m_ph = 0;
    tag_t = "R1"; tag_d = "R1";
    check_all();

    // R10: mode change alone, no ticks
    tag_t = "R10"; tag_d = "R10";
    hour24 = 1'b1; step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    hour24 = 1'b0; step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);

    // R5: noon and one o'clock in 12-hour coding
    tag_t = "R5"; tag_d = "R6";
    load_all(1'b0, 24'h115958, 24'h230615, 3'd2);
    ticks(2 * TPS);
    load_all(1'b0, 24'h125959, 24'h230615, 3'd2); ticks(TPS);
    load_all(1'b0, 24'h325959, 24'h230615, 3'd2); ticks(TPS);
    // R5/R6/R8: midnight in 12-hour coding, end of February in a common year, Saturday wrap
    load_all(1'b0, 24'h315959, 24'h230228, 3'd6); ticks(TPS);
    cmp(time_q, 24'h120000, "R5", "12h midnight");
    cmp(date_q, 24'h230301, "R6", "feb28 rollover");
    cmp({21'd0, wday_q}, 24'd0, "R8", "weekday wrap");

    // R4/R6: end of century in 24-hour coding
    tag_t = "R4"; tag_d = "R6";
    load_all(1'b1, 24'h235959, 24'h991231, 3'd3); ticks(TPS);
    cmp(date_q, 24'h000101, "R6", "year wrap");
    // R7: leap February
    tag_d = "R7";
    load_all(1'b1, 24'h235959, 24'h040228, 3'd1); ticks(TPS);
    cmp(date_q, 24'h040229, "R7", "feb29");
    load_all(1'b1, 24'h235959, 24'h040229, 3'd1); ticks(TPS);
    // R6: thirty-day month
    tag_d = "R6";
    load_all(1'b1, 24'h235959, 24'h230430, 3'd1); ticks(TPS);
    // R3: minute and hour carry
    tag_t = "R3";
    load_all(1'b1, 24'h095959, 24'h230101, 3'd0); ticks(TPS);
    cmp(time_q, 24'h100000, "R3", "hour carry");

    // R9: load restarts a partly counted second, load beats tick, holes masked
    tag_t = "R9"; tag_d = "R9";
    ticks(TPS - 1);
    step(1'b1, 1'b1, 24'hFFFF45 & 24'h3F7F45 | 24'h008080, 1'b0, '0, 1'b0, '0);
    ticks(TPS - 1);
    cmp(time_q[7:0], 8'h45, "R9", "no step before full phase");
    ticks(1);
    step(1'b1, 1'b0, '0, 1'b1, 24'hFFFFFF, 1'b0, '0);

    // R2: irregular base ticks
    tag_t = "R2"; tag_d = "R2";
    load_all(1'b1, 24'h120000, 24'h230101, 3'd0);
    for (int i = 0; i < 200; i++)
      step(1'($urandom_range(0, 1)), 1'b0, '0, 1'b0, '0, 1'b0, '0);

    // Random loads near and away from rollovers
    tag_t = "R3"; tag_d = "R6";
    for (int it = 0; it < 150; it++) begin
      logic m24, near;
      int yr, mo, dy, hr;
      logic [23:0] tv, dv;
      m24  = 1'($urandom_range(0, 1));
      near = 1'($urandom_range(0, 1));
      yr = $urandom_range(0, 99);
      mo = near ? ((it % 3 == 0) ? 2 : 12 - $urandom_range(0, 11)) : $urandom_range(1, 12);
      dy = near ? dim(mo, yr) : $urandom_range(1, dim(mo, yr));
      if (m24) hr = near ? 23 : $urandom_range(0, 23);
      else     hr = near ? 11 : $urandom_range(1, 12);
      tv[23:16] = to_bcd(hr) + ((!m24 && ($urandom_range(0, 1) == 1 || near)) ? 8'h20 : 8'h00);
      tv[15:8]  = near ? 8'h59 : to_bcd($urandom_range(0, 59));
      tv[7:0]   = near ? to_bcd($urandom_range(50, 59)) : to_bcd($urandom_range(0, 59));
      dv = {to_bcd(yr), to_bcd(mo), to_bcd(dy)};
      hour24 = m24;
      step(1'b0, 1'b1, tv, 1'($urandom_range(0, 1)) | near, dv, 1'($urandom_range(0, 1)),
           3'($urandom_range(0, 6)));
      for (int c = 0; c < 40; c++)
        step(1'($urandom_range(0, 3) != 0), 1'b0, '0, 1'b0, '0, 1'b0, '0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule